// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit bidirectional buses, called A and B. Each bus is modelled as three separate vectors: an input, an output and a per-bit output enable. Tri-state drive is therefore explicit, and the pad logic outside the block merges the three. Each transfer direction has its own storage register with its own rising-edge clock. The A-to-B register samples bus A, and the B-to-A register samples bus B.

An active-low enable and a direction input decide which bus is driven, if either. For the direction in use, a select input chooses the source for the driven bus. That source is either the live value on the opposite bus or the value held in that direction's register. Capture never depends on drive. Both registers keep loading on their own clock edges while the buses are isolated and while a live path is selected. A system can therefore snapshot traffic on either bus at any time and replay it later.

Top module: `regBusXcvr`

## Requirements
- R1: Both registers are 8 bits wide and clear to zero asynchronously while `rstN` is low. In stored mode the reset value is driven even if no capture edge has occurred since reset.
- R2: On each rising edge of `clkAtoB` while out of reset, the A-to-B register loads `aIn`.
- R3: On each rising edge of `clkBtoA` while out of reset, the B-to-A register loads `bIn`.
- R4: While `enN` is 1, `aOe` and `bOe` are all zeros.
- R5: While `enN` is 0, the enables are set as follows. With `dirAtoB` = 1, `bOe` is all ones and `aOe` is all zeros. With `dirAtoB` = 0, `aOe` is all ones and `bOe` is all zeros.
- R6: When the driven bus has its select at 0, its output equals the live input of the opposite bus. The select is `selAtoB` for bus B and `selBtoA` for bus A. The output follows the opposite bus combinationally, with no clock edge needed.
- R7: When the driven bus has its select at 1, its output equals the register of that direction. A capture edge makes the newly loaded value appear on the output.
- R8: Capture into both registers continues while `enN` is 1, and also while the live source is selected.
- R9: `aOe` and `bOe` are never both non-zero.
- R10: A bus that is not driven presents all zeros on its output vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkAtoB | input | 1 | Rising-edge capture clock for the A-to-B register |
| clkBtoA | input | 1 | Rising-edge capture clock for the B-to-A register |
| rstN | input | 1 | Asynchronous active-low reset of both registers |
| enN | input | 1 | Active-low output enable for the whole transceiver |
| dirAtoB | input | 1 | 1: drive bus B; 0: drive bus A (when enabled) |
| selAtoB | input | 1 | Source for bus B: 0 live bus A, 1 A-to-B register |
| selBtoA | input | 1 | Source for bus A: 0 live bus B, 1 B-to-A register |
| aIn | input | 8 | Value sensed on bus A |
| aOut | output | 8 | Value driven onto bus A |
| aOe | output | 8 | Per-bit drive enable for bus A |
| bIn | input | 8 | Value sensed on bus B |
| bOut | output | 8 | Value driven onto bus B |
| bOe | output | 8 | Per-bit drive enable for bus B |

## Verification
The drive enables and the live paths are combinational. Their results are due in the same cycle the inputs change. Stored values are due directly after the capture clock's rising edge, with no extra register on the path. The bench changes inputs shortly after each edge of the sampling clock and raises a capture clock a little later. It then compares every output with its reference model on the falling edge, after the inputs and any capture have settled. The checker relates each register's output to the bus value sampled at the previous capture edge of that register's own clock.

// File: rtl/regBusXcvr_pkg.sv
package regBusXcvr_pkg;

  // Strobes from the drive decoder to the datapath.
  typedef struct packed {
    logic driveA;     // bus A output stage enabled
    logic driveB;     // bus B output stage enabled
    logic storedToA;  // bus A source is the B-to-A register
    logic storedToB;  // bus B source is the A-to-B register
  } xcvrStrobes_t;

endpackage

// File: rtl/captureReg.sv
module captureReg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= d;
  end

endmodule

// File: rtl/xcvrCtrl.sv
module xcvrCtrl
  import regBusXcvr_pkg::*;
(
  input  logic         enN,
  input  logic         dirAtoB,
  input  logic         selAtoB,
  input  logic         selBtoA,
  output xcvrStrobes_t strobes
);

  logic enabled;
  assign enabled = ~enN;

  always_comb begin
    strobes           = '0;
    strobes.driveB    = enabled &  dirAtoB;
    strobes.driveA    = enabled & ~dirAtoB;
    strobes.storedToB = selAtoB;
    strobes.storedToA = selBtoA;
  end

endmodule

// File: rtl/xcvrDatapath.sv
module xcvrDatapath
  import regBusXcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clkAtoB,
  input  logic             clkBtoA,
  input  logic             rstN,
  input  xcvrStrobes_t     strobes,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOe,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOe
);

  logic [WIDTH-1:0] heldAtoB;
  logic [WIDTH-1:0] heldBtoA;
  logic [WIDTH-1:0] srcToB;
  logic [WIDTH-1:0] srcToA;

  captureReg #(.WIDTH(WIDTH)) i_regAtoB (
    .clk (clkAtoB),
    .rstN(rstN),
    .d   (aIn),
    .q   (heldAtoB)
  );

  captureReg #(.WIDTH(WIDTH)) i_regBtoA (
    .clk (clkBtoA),
    .rstN(rstN),
    .d   (bIn),
    .q   (heldBtoA)
  );

  assign srcToB = strobes.storedToB ? heldAtoB : aIn;
  assign srcToA = strobes.storedToA ? heldBtoA : bIn;

  for (genvar bitIdx = 0; bitIdx < WIDTH; bitIdx++) begin : g_lane
    assign bOe[bitIdx]  = strobes.driveB;
    assign aOe[bitIdx]  = strobes.driveA;
    assign bOut[bitIdx] = strobes.driveB & srcToB[bitIdx];
    assign aOut[bitIdx] = strobes.driveA & srcToA[bitIdx];
  end

endmodule

// File: rtl/regBusXcvr.sv
module regBusXcvr
  import regBusXcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clkAtoB,
  input  logic             clkBtoA,
  input  logic             rstN,
  input  logic             enN,
  input  logic             dirAtoB,
  input  logic             selAtoB,
  input  logic             selBtoA,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOe
);

  xcvrStrobes_t strobes;

  xcvrCtrl i_ctrl (
    .enN    (enN),
    .dirAtoB(dirAtoB),
    .selAtoB(selAtoB),
    .selBtoA(selBtoA),
    .strobes(strobes)
  );

  xcvrDatapath #(.WIDTH(WIDTH)) i_data (
    .clkAtoB(clkAtoB),
    .clkBtoA(clkBtoA),
    .rstN   (rstN),
    .strobes(strobes),
    .aIn    (aIn),
    .bIn    (bIn),
    .aOut   (aOut),
    .aOe    (aOe),
    .bOut   (bOut),
    .bOe    (bOe)
  );

endmodule

// File: rtl/regBusXcvr_chk.sv
module regBusXcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clkAtoB,
  input logic             clkBtoA,
  input logic             rstN,
  input logic             enN,
  input logic             dirAtoB,
  input logic             selAtoB,
  input logic             selBtoA,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aOut,
  input logic [WIDTH-1:0] aOe,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] bOut,
  input logic [WIDTH-1:0] bOe
);

  logic showHeldB;
  logic showHeldA;
  assign showHeldB = !enN && dirAtoB && selAtoB;
  assign showHeldA = !enN && !dirAtoB && selBtoA;

  // R9: never both buses driven (checked in both clock domains)
  p_one_side_ab_r9: assert property (@(posedge clkAtoB) disable iff (!rstN)
    !((|aOe) && (|bOe)));
  p_one_side_ba_r9: assert property (@(posedge clkBtoA) disable iff (!rstN)
    !((|aOe) && (|bOe)));

  // R4: isolation releases both buses
  p_isolate_r4: assert property (@(posedge clkAtoB) disable iff (!rstN)
    enN |-> (aOe == '0 && bOe == '0));

  // R5: direction picks the driven bus
  p_dir_b_r5: assert property (@(posedge clkAtoB) disable iff (!rstN)
    (!enN && dirAtoB) |-> (bOe == '1 && aOe == '0));

  // R6: live path to B follows bus A
  p_live_b_r6: assert property (@(posedge clkAtoB) disable iff (!rstN)
    (!enN && dirAtoB && !selAtoB) |-> bOut == aIn);

  // R7 / R2: stored path to B shows value captured at previous edge
  p_held_b_r7: assert property (@(posedge clkAtoB) disable iff (!rstN)
    showHeldB ##1 showHeldB |-> bOut == $past(aIn));

  // R7 / R3: stored path to A shows value captured at previous edge
  p_held_a_r7: assert property (@(posedge clkBtoA) disable iff (!rstN)
    showHeldA ##1 showHeldA |-> aOut == $past(bIn));

  // R10: undriven bus shows zeros
  p_idle_zero_r10: assert property (@(posedge clkBtoA) disable iff (!rstN)
    ((aOe == '0) |-> aOut == '0) and ((bOe == '0) |-> bOut == '0));

endmodule

bind regBusXcvr regBusXcvr_chk #(.WIDTH(WIDTH)) i_chk (
  .clkAtoB(clkAtoB),
  .clkBtoA(clkBtoA),
  .rstN   (rstN),
  .enN    (enN),
  .dirAtoB(dirAtoB),
  .selAtoB(selAtoB),
  .selBtoA(selBtoA),
  .aIn    (aIn),
  .aOut   (aOut),
  .aOe    (aOe),
  .bIn    (bIn),
  .bOut   (bOut),
  .bOe    (bOe)
);

// File: tb/test_regBusXcvr.sv
`timescale 1ns/1ps
module test_regBusXcvr;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clkAtoB = 1'b0, clkBtoA = 1'b0;
  logic         rstN = 1'b0;
  logic         enN = 1'b1, dirAtoB = 1'b0, selAtoB = 1'b0, selBtoA = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, aOe, bOut, bOe;

  int  checks = 0;
  int  fails = 0;
  int  cycles = 0;
  bit  checkOn = 1'b0;
  bit  done = 1'b0;
  string phase = "R1";

  // behavioural model state
  logic [W-1:0] mAtoB = '0, mBtoA = '0;

  always #2.5 clk = ~clk;

  regBusXcvr #(.WIDTH(W)) i_regBusXcvr (
    .clkAtoB(clkAtoB), .clkBtoA(clkBtoA), .rstN(rstN),
    .enN(enN), .dirAtoB(dirAtoB), .selAtoB(selAtoB), .selBtoA(selBtoA),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s): actual %h expected %h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  // reference comparison on every falling edge
  always @(negedge clk) begin
    if (checkOn) begin
      logic [W-1:0] eAOe, eBOe, eAOut, eBOut;
      eBOe  = (!enN && dirAtoB)  ? '1 : '0;
      eAOe  = (!enN && !dirAtoB) ? '1 : '0;
      eBOut = (eBOe == '0) ? '0 : (selAtoB ? mAtoB : aIn);
      eAOut = (eAOe == '0) ? '0 : (selBtoA ? mBtoA : bIn);
      check(aOe, eAOe, enN ? "R4 aOe" : "R5 aOe");
      check(bOe, eBOe, enN ? "R4 bOe" : "R5 bOe");
      check(bOut, eBOut, (eBOe == '0) ? "R10 bOut" : (selAtoB ? "R7 bOut" : "R6 bOut"));
      check(aOut, eAOut, (eAOe == '0) ? "R10 aOut" : (selBtoA ? "R7 aOut" : "R6 aOut"));
      checks++;
      if ((|aOe) && (|bOe)) begin
        fails++;
        $display("FAIL R9: aOe %h bOe %h both active, expected one idle", aOe, bOe);
      end
    end
  end

  // one sampling-clock step: drive inputs, optionally pulse capture clocks
  task automatic step(input logic en_n, input logic dir, input logic sab,
                      input logic sba, input logic [W-1:0] a,
                      input logic [W-1:0] b, input bit pAB, input bit pBA);
    @(posedge clk);
    #1;
    enN = en_n; dirAtoB = dir; selAtoB = sab; selBtoA = sba;
    aIn = a; bIn = b;
    #1;
    if (pAB) begin clkAtoB = 1'b1; if (rstN) mAtoB = aIn; end  // R2
    if (pBA) begin clkBtoA = 1'b1; if (rstN) mBtoA = bIn; end  // R3
    #2;
    clkAtoB = 1'b0; clkBtoA = 1'b0;
  endtask

  initial begin : watchdog
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    // R1: edges during reset load nothing
    checkOn = 1'b1;
    phase = "R1 in reset";
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h5A, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'hC3, 1'b1, 1'b1);
    @(posedge clk); #1 rstN = 1'b1;

    // R1: reset value driven in stored mode before any capture
    phase = "R1 after reset";
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'hEE, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'hDD, 8'hCC, 1'b0, 1'b0);

    // R8: capture while isolated, then show stored values
    phase = "R8 isolated capture";
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h12, 8'h34, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);

    // R8: capture in live mode, then reveal
    phase = "R8 live capture";
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h77, 8'h88, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h01, 8'h02, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 8'h02, 1'b0, 1'b0);

    // R2/R3/R7: capture in stored mode appears at once
    phase = "R7 stored capture";
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h9E, 8'h6B, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h9E, 8'h6B, 1'b0, 1'b0);

    // full sweep of enable, direction and both selects
    phase = "R4-sweep";
    for (int pat = 0; pat < 6; pat++) begin
      for (int combo = 0; combo < 16; combo++) begin
        logic [W-1:0] av, bv;
        av = 8'(pat * 37 + combo * 11 + 8'h15);
        bv = 8'(~(pat * 53 + combo * 7));
        step(combo[3], combo[2], combo[1], combo[0], av, bv,
             (combo + pat) % 2 == 0, (combo + pat) % 3 == 0);
        step(combo[3], combo[2], combo[1], combo[0], ~av, ~bv, 1'b0, 1'b0);
      end
    end

    // R1: asynchronous reset clears registers mid-run
    phase = "R1 async reset";
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hF0, 8'h0F, 1'b1, 1'b1);
    @(posedge clk); #1.5 rstN = 1'b0; mAtoB = '0; mBtoA = '0;
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hAA, 8'h55, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h55, 1'b0, 1'b0);

    @(posedge clk);
    checkOn = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule